// File: doc/BRIEF.md
# Streaming Pixel Scalar Adder

This block adds one constant byte to every pixel of a grayscale raster that passes through it as a stream. Pixels are 8-bit unsigned values with a single channel. Each beat on the valid/ready input carries either one pixel or eight pixels, chosen by a parameter. In the eight-pixel build, eight independent byte adders work side by side, and all of them use the same scalar.

A second parameter fixes how sums above 255 are handled. They are either clamped to 255 or cut down to their low eight bits. The scalar sits in a register. It is written through a one-cycle strobe, and a write that lands inside a frame is held back until that frame has ended. Image height and width are run-time inputs, bounded by parameters. From them the block counts beats and rows, and it marks the last beat of each line and of the frame on its output.

There is one register stage between the input stream and the output stream. A stalled consumer freezes that stage, and the stall propagates back to the producer.

Top module: `pix_scalar_add`

## Requirements
- R1: After a synchronous active-low reset, `m_valid` is 0 and `s_ready` is 1.
- R2: Lane l of a beat occupies bits [8l+7:8l], where lane 0 is the lowest-addressed pixel. Each output lane is the input pixel in that same lane plus the active scalar, and one single scalar byte serves every lane.
- R3: With `SATURATE` = 1, a lane whose sum exceeds 255 outputs 255.
- R4: With `SATURATE` = 0, a lane outputs the low eight bits of the sum.
- R5: An input beat accepted on a clock edge (`s_valid` and `s_ready` both high) is presented on the output, with `m_valid` high, right after that edge.
- R6: While `m_valid` is 1 and `m_ready` is 0, the output beat is held unchanged. Every accepted beat leaves exactly once, in order. `s_ready` is high whenever the output stage is empty.
- R7: `m_eol` is 1 on the last beat of each row, the beat whose index within the row is `cols_in`/`LANES` − 1, and 0 on all other beats.
- R8: `m_eof` is 1 only on the last beat of the last row, the row with index `rows_in` − 1. `m_eof` implies `m_eol`. After that beat, the next beat starts row 0, column 0.
- R9: A scalar write made while no frame is in progress applies to every beat of the next frame.
- R10: A scalar write made while a frame is in progress leaves the rest of that frame unchanged. It applies from the first beat of the following frame, including when that frame follows back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_wr | input | 1 | Scalar write strobe |
| scl_din | input | 8 | Scalar value to write |
| rows_in | input | $clog2(MAX_ROWS+1) | Frame height in rows |
| cols_in | input | $clog2(MAX_COLS+1) | Frame width in pixels, a multiple of LANES |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | 8*LANES | Input pixels, lane 0 in the low byte |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer takes the output beat |
| m_data | output | 8*LANES | Output pixels, lane 0 in the low byte |
| m_eol | output | 1 | Last beat of a row |
| m_eof | output | 1 | Last beat of the frame |

## Verification
Every result appears one cycle after the edge that accepts its input beat. The sum, the line marker and the frame marker come out of the same register stage at the same time. Once it is presented, a beat stays put for as many cycles as `m_ready` stays low. The bench therefore drives on the falling edge and samples one time unit later, reading exactly the values that the next rising edge will see. An output beat is compared against the head of an expected queue only in a cycle where both `m_valid` and `m_ready` are high. The bench also checks that a beat accepted in one cycle shows `m_valid` in the next sampled cycle. A stalled beat must read back identical in the cycle that follows. For the deferred scalar write, the expected values change exactly at the frame boundary. The two frames involved are sent back-to-back, so any early or late switch shows up in the data.

// File: rtl/pxadd_pkg.sv
// Shared types and constants for the pixel scalar adder.
// Assumes 8-bit unsigned single-channel pixels.
package pxadd_pkg;
    localparam int PIX_W = 8;
    typedef logic [PIX_W-1:0] pix_t;
    localparam pix_t PIX_MAX = '1;
endpackage

// File: rtl/pxadd_lane.sv
// One byte-lane adder: pixel plus scalar with a policy picked at build time.
// Assumes both operands are unsigned; purely combinational.
module pxadd_lane
    import pxadd_pkg::*;
#(
    parameter bit SATURATE = 1'b1
) (
    input  pix_t pix_i,
    input  pix_t scl_i,
    output pix_t pix_o
);
    generate
        if (SATURATE) begin : g_sat
            logic [PIX_W:0] sum;
            // Widen by one bit and clamp when the carry is set.
            assign sum   = {1'b0, pix_i} + {1'b0, scl_i};
            assign pix_o = sum[PIX_W] ? PIX_MAX : sum[PIX_W-1:0];
        end else begin : g_wrap
            // Modulo-256 sum: the carry is discarded.
            assign pix_o = pix_i + scl_i;
        end
    endgenerate
endmodule

// File: rtl/pxadd_pos.sv
// Beat and row position tracker for one frame.
// Assumes rows and beats-per-row are at least 1 and stay stable inside a frame.
module pxadd_pos #(
    parameter int ROW_W = 7,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic [COL_W-1:0] bpr_i,
    output logic             at_eol_o,
    output logic             at_eof_o,
    output logic             busy_o
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Markers for the beat currently at the input.
    assign at_eol_o = (col_q == bpr_i - COL_W'(1));
    assign at_eof_o = at_eol_o && (row_q == rows_i - ROW_W'(1));
    assign busy_o   = (col_q != '0) || (row_q != '0);

    // Step the position on each accepted beat and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (adv_i) begin
            if (at_eol_o) begin
                col_q <= '0;
                row_q <= at_eof_o ? '0 : row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/pxadd_scalar.sv
// Scalar holding register with deferral of writes made inside a frame.
// Assumes busy_i is high between the first and the last beat of a frame.
module pxadd_scalar
    import pxadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  pix_t din_i,
    input  logic busy_i,
    input  logic acc_i,
    input  logic close_i,
    output pix_t scl_o
);
    pix_t act_q;
    pix_t pend_q;
    logic pend_v_q;
    logic frame_open;
    logic boundary;

    assign frame_open = busy_i || acc_i;
    assign boundary   = !frame_open || close_i;
    assign scl_o      = act_q;

    // Apply a write at once between frames, otherwise park it until the frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (boundary) begin
            if (wr_i) begin
                act_q <= din_i;
            end else if (pend_v_q) begin
                act_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (wr_i) begin
            pend_q   <= din_i;
            pend_v_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pix_scalar_add.sv
// Streaming pixel scalar adder: LANES byte lanes, one register stage.
// Assumes cols_in is a multiple of LANES, LANES is 1 or 8, and dimensions stay stable inside a frame.
module pix_scalar_add
    import pxadd_pkg::*;
#(
    parameter int LANES    = 8,
    parameter bit SATURATE = 1'b1,
    parameter int MAX_ROWS = 64,
    parameter int MAX_COLS = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_wr,
    input  logic [7:0]                     scl_din,
    input  logic [$clog2(MAX_ROWS+1)-1:0]  rows_in,
    input  logic [$clog2(MAX_COLS+1)-1:0]  cols_in,
    input  logic                           s_valid,
    output logic                           s_ready,
    input  logic [8*LANES-1:0]             s_data,
    output logic                           m_valid,
    input  logic                           m_ready,
    output logic [8*LANES-1:0]             m_data,
    output logic                           m_eol,
    output logic                           m_eof
);
    localparam int ROW_W   = $clog2(MAX_ROWS+1);
    localparam int COL_W   = $clog2(MAX_COLS+1);
    localparam int DATA_W  = PIX_W * LANES;
    localparam int LANE_SH = $clog2(LANES);

    logic              acc;
    logic              at_eol;
    logic              at_eof;
    logic              frame_busy;
    pix_t              scl_act;
    logic [COL_W-1:0]  bpr;
    logic [DATA_W-1:0] sum_d;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              eol_q;
    logic              eof_q;

    // Take a beat whenever the output stage is empty or draining.
    assign s_ready = !valid_q || m_ready;
    assign acc     = s_valid && s_ready;
    assign bpr     = cols_in >> LANE_SH;

    pxadd_pos #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (acc),
        .rows_i   (rows_in),
        .bpr_i    (bpr),
        .at_eol_o (at_eol),
        .at_eof_o (at_eof),
        .busy_o   (frame_busy)
    );

    pxadd_scalar u_scl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (scl_wr),
        .din_i   (scl_din),
        .busy_i  (frame_busy),
        .acc_i   (acc),
        .close_i (acc && at_eof),
        .scl_o   (scl_act)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            pxadd_lane #(
                .SATURATE (SATURATE)
            ) u_lane (
                .pix_i (s_data[l*PIX_W +: PIX_W]),
                .scl_i (scl_act),
                .pix_o (sum_d[l*PIX_W +: PIX_W])
            );
        end
    endgenerate

    // Output stage: load on accept, drop valid once the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            eol_q   <= 1'b0;
            eof_q   <= 1'b0;
        end else if (acc) begin
            valid_q <= 1'b1;
            data_q  <= sum_d;
            eol_q   <= at_eol;
            eof_q   <= at_eof;
        end else if (m_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign m_valid = valid_q;
    assign m_data  = data_q;
    assign m_eol   = eol_q;
    assign m_eof   = eof_q;
endmodule

// File: rtl/pxadd_chk.sv
// Assertion checker for pix_scalar_add, attached by bind below.
// Assumes it sees the top's ports plus its accept, position and scalar signals.
module pxadd_chk #(
    parameter int LANES    = 8,
    parameter bit SATURATE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_valid,
    input logic               s_ready,
    input logic [8*LANES-1:0] s_data,
    input logic               m_valid,
    input logic               m_ready,
    input logic [8*LANES-1:0] m_data,
    input logic               m_eol,
    input logic               m_eof,
    input logic               acc,
    input logic               at_eof,
    input logic               frame_busy,
    input logic [7:0]         scl_act
);
    // R5: an accepted beat is on the output next cycle.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid);

    // R6: a stalled beat is held unchanged.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_eol) && $stable(m_eof)));

    // R6: an empty output stage never back-pressures.
    p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_valid |-> s_ready);

    // R8: the frame marker only comes with the line marker.
    p_eof_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_eof) |-> m_eol);

    // R10: the scalar stays fixed inside a frame except at its closing beat.
    p_scl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && !(acc && at_eof)) |=> $stable(scl_act));

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
            // R2: a zero scalar passes the lane through.
            p_zero_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (acc && scl_act == 8'd0) |=> (m_data[l*8 +: 8] == $past(s_data[l*8 +: 8])));
            if (SATURATE) begin : g_sat_chk
                // R3: a clamped sum never falls below its input pixel.
                p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    acc |=> (m_data[l*8 +: 8] >= $past(s_data[l*8 +: 8])));
            end
        end
    endgenerate
endmodule

bind pix_scalar_add pxadd_chk #(
    .LANES    (LANES),
    .SATURATE (SATURATE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_eol      (m_eol),
    .m_eof      (m_eof),
    .acc        (acc),
    .at_eof     (at_eof),
    .frame_busy (frame_busy),
    .scl_act    (scl_act)
);

// File: tb/test_pix_scalar_add.sv
`timescale 1ns/1ps
// Bench: a saturating and a wrapping eight-lane instance share one stimulus stream.
module test_pix_scalar_add;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_wr = 1'b0;
    logic [7:0]  scl_din = '0;
    logic [6:0]  rows_in = 7'd1;
    logic [8:0]  cols_in = 9'd8;
    logic        s_valid = 1'b0;
    logic [63:0] s_data = '0;
    logic        m_ready = 1'b0;
    logic        s_ready_s, s_ready_w;
    logic        m_valid_s, m_valid_w;
    logic [63:0] m_data_s, m_data_w;
    logic        m_eol_s, m_eol_w, m_eof_s, m_eof_w;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] in_d[$];
    logic [6:0]  in_r[$];
    logic [8:0]  in_c[$];
    bit          in_w[$];
    logic [7:0]  in_v[$];
    logic [63:0] ex_s[$];
    logic [63:0] ex_w[$];
    bit          ex_eol[$];
    bit          ex_eof[$];
    string       ex_tag[$];

    always #10 clk = ~clk;

    pix_scalar_add #(.LANES(8), .SATURATE(1'b1)) i_pix_scalar_add (
        .clk(clk), .rst_n(rst_n), .scl_wr(scl_wr), .scl_din(scl_din),
        .rows_in(rows_in), .cols_in(cols_in), .s_valid(s_valid), .s_ready(s_ready_s),
        .s_data(s_data), .m_valid(m_valid_s), .m_ready(m_ready), .m_data(m_data_s),
        .m_eol(m_eol_s), .m_eof(m_eof_s));

    pix_scalar_add #(.LANES(8), .SATURATE(1'b0)) i_pix_scalar_add_wrap (
        .clk(clk), .rst_n(rst_n), .scl_wr(scl_wr), .scl_din(scl_din),
        .rows_in(rows_in), .cols_in(cols_in), .s_valid(s_valid), .s_ready(s_ready_w),
        .s_data(s_data), .m_valid(m_valid_w), .m_ready(m_ready), .m_data(m_data_w),
        .m_eol(m_eol_w), .m_eof(m_eof_w));

    // Reference sum for one lane under either policy.
    function automatic logic [7:0] ref_lane(logic [7:0] p, logic [7:0] s, bit sat);
        logic [8:0] t;
        t = {1'b0, p} + {1'b0, s};
        if (sat && t[8]) return 8'hFF;
        return t[7:0];
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Queue one frame; mode 0 random, 1 near 255, 2 ascending, 3 all 0xFF.
    task automatic gen_frame(int rows, int bpr, logic [7:0] scl, int mode,
                             int wr_idx, logic [7:0] wr_val, string tag);
        for (int r = 0; r < rows; r++) begin
            for (int b = 0; b < bpr; b++) begin
                logic [63:0] d, es, ew;
                int idx;
                idx = r * bpr + b;
                for (int l = 0; l < 8; l++) begin
                    logic [7:0] p;
                    case (mode)
                        0: p = 8'($urandom_range(0, 255));
                        1: p = 8'hF0 + 8'($urandom_range(0, 15));
                        2: p = 8'(idx * 8 + l);
                        default: p = 8'hFF;
                    endcase
                    d[l*8 +: 8]  = p;
                    es[l*8 +: 8] = ref_lane(p, scl, 1'b1);
                    ew[l*8 +: 8] = ref_lane(p, scl, 1'b0);
                end
                in_d.push_back(d);
                in_r.push_back(7'(rows));
                in_c.push_back(9'(bpr * 8));
                in_w.push_back(idx == wr_idx);
                in_v.push_back(wr_val);
                ex_s.push_back(es);
                ex_w.push_back(ew);
                ex_eol.push_back(b == bpr - 1);
                ex_eof.push_back((b == bpr - 1) && (r == rows - 1));
                ex_tag.push_back(tag);
            end
        end
    endtask

    // Scalar write while the stream is idle (R9).
    task automatic write_idle(logic [7:0] v);
        @(negedge clk);
        s_valid = 1'b0;
        scl_wr  = 1'b1;
        scl_din = v;
        @(negedge clk);
        scl_wr  = 1'b0;
    endtask

    // Drive queued beats with random gaps and back-pressure; check every output.
    task automatic run_stream();
        bit prev_hold = 1'b0;
        bit prev_in = 1'b0;
        logic [63:0] prev_d = '0;
        int guard = 0;
        while ((in_d.size() > 0 || ex_s.size() > 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
            m_ready = ($urandom_range(0, 9) < 7);
            scl_wr  = 1'b0;
            if (in_d.size() > 0 && $urandom_range(0, 9) < 8) begin
                s_valid = 1'b1;
                s_data  = in_d[0];
                rows_in = in_r[0];
                cols_in = in_c[0];
                if (in_w[0]) begin
                    scl_wr  = 1'b1;
                    scl_din = in_v[0];
                    in_w[0] = 1'b0;
                end
            end else begin
                s_valid = 1'b0;
            end
            #1;
            if (prev_in)
                chk(m_valid_s && m_valid_w, "R5 valid after accept", {62'd0, m_valid_s, m_valid_w}, 64'd3);
            if (prev_hold)
                chk(m_valid_s && m_data_s == prev_d, "R6 stalled beat held", m_data_s, prev_d);
            if (m_valid_s && m_ready) begin
                if (ex_s.size() == 0) begin
                    chk(1'b0, "R6 unexpected beat", m_data_s, 64'd0);
                end else begin
                    string t;
                    t = ex_tag.pop_front();
                    chk(m_data_s == ex_s[0], {"R3 saturate ", t}, m_data_s, ex_s[0]);
                    chk(m_data_w == ex_w[0], {"R4 wrap ", t}, m_data_w, ex_w[0]);
                    chk(m_eol_s == ex_eol[0] && m_eol_w == ex_eol[0], "R7 end of line",
                        {63'd0, m_eol_s}, {63'd0, ex_eol[0]});
                    chk(m_eof_s == ex_eof[0] && m_eof_w == ex_eof[0], "R8 end of frame",
                        {63'd0, m_eof_s}, {63'd0, ex_eof[0]});
                    void'(ex_s.pop_front());
                    void'(ex_w.pop_front());
                    void'(ex_eol.pop_front());
                    void'(ex_eof.pop_front());
                end
            end
            prev_hold = m_valid_s && !m_ready;
            prev_d    = m_data_s;
            prev_in   = s_valid && s_ready_s;
            if (prev_in) begin
                void'(in_d.pop_front());
                void'(in_r.pop_front());
                void'(in_c.pop_front());
                void'(in_w.pop_front());
                void'(in_v.pop_front());
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        scl_wr  = 1'b0;
        chk(ex_s.size() == 0 && in_d.size() == 0, "R6 all beats delivered",
            64'(ex_s.size()), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty output stage, ready to accept.
        chk(!m_valid_s && !m_valid_w, "R1 valid low after reset", {62'd0, m_valid_s, m_valid_w}, 64'd0);
        chk(s_ready_s && s_ready_w, "R1 ready high after reset", {62'd0, s_ready_s, s_ready_w}, 64'd3);

        // R2: zero scalar passes pixels; ascending pattern pins the lane order.
        write_idle(8'd0);
        gen_frame(2, 2, 8'd0, 2, -1, 8'd0, "R2 lane order");
        gen_frame(1, 1, 8'd0, 3, -1, 8'd0, "R2 zero scalar");
        run_stream();

        // R3/R4: scalar 255 on random and all-ones pixels.
        write_idle(8'd255);
        gen_frame(2, 3, 8'd255, 0, -1, 8'd0, "R9 scalar 255");
        gen_frame(1, 2, 8'd255, 3, -1, 8'd0, "R9 scalar 255 on 0xFF");
        run_stream();

        // Pixels near 255 with a scalar of 1.
        write_idle(8'd1);
        gen_frame(3, 3, 8'd1, 1, -1, 8'd0, "R3 near full scale");
        run_stream();

        // R10: write 200 in mid-frame; the next frame follows back-to-back.
        write_idle(8'd37);
        gen_frame(4, 2, 8'd37, 2, 5, 8'd200, "R10 old scalar kept");
        gen_frame(2, 2, 8'd200, 0, -1, 8'd0, "R10 new scalar applied");
        gen_frame(1, 1, 8'd200, 1, -1, 8'd0, "R8 single beat frame");
        run_stream();

        // R9: random scalars written between frames of random size.
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            v = 8'($urandom_range(0, 255));
            write_idle(v);
            gen_frame($urandom_range(1, 5), $urandom_range(1, 4), v,
                      $urandom_range(0, 3), -1, 8'd0, "R9 random frame");
            run_stream();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule